// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Integer Core

This block is a small 32-bit in-order processor core. It runs four kinds of instruction: register-to-register arithmetic and logic, word load, word store and branch-on-equal. The instruction path has five stages: fetch, decode with register read, execute, memory, and register write-back. A pipeline register sits between each pair of stages, so one instruction can start and one can finish in every cycle. Each functional unit is used in the same stage by every instruction. Arithmetic results pass through the memory stage without doing anything there, so every register write happens in stage 5.

The core contains its own instruction memory and data memory, both plain arrays. While reset is held, a loader port on each memory fills them. Hazards are left to the program. Nothing is forwarded and nothing stalls. A branch is resolved in the memory stage, so the three instructions after it always execute. An instruction that reads a register written by a load, or by any earlier instruction, must be at least three places behind that producer. Three ports expose what the core does: the fetch address, the register write-back port and the data-memory store port.

Top module: `pipe5_core`

## Requirements
- R1: Synchronous reset, active high, sets the fetch address to 0 and empties every pipeline stage, so neither a register write nor a store is signalled. With no taken branch, the fetch address then grows by 4 in every cycle.
- R2: Instruction fields are: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, function in 5:0 and a 16-bit immediate in 15:0. The opcodes are 0x00 (register operation), 0x23 (load), 0x2B (store) and 0x04 (branch-on-equal). Any other opcode, and any register operation with an unlisted function code, writes neither a register nor memory.
- R3: The register operations are selected by function code: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). The result is written to rd and appears on the write-back port in the fifth cycle of the instruction, which is fetch cycle + 4.
- R4: A load reads the data word at rs + sign-extended immediate, using address bits above bit 1. It writes that word to rt, shown on the write-back port at fetch cycle + 4.
- R5: A store writes rt to the data word at rs + sign-extended immediate during the memory stage. It is shown on the store port at fetch cycle + 3, and a load that reaches the memory stage later reads the new value. A store performs no register write.
- R6: A branch-on-equal whose two registers match loads the fetch address with its own address + 4 + (sign-extended offset × 4). The new address is in place at fetch cycle + 4, and the three instructions fetched after the branch still complete. A non-matching branch lets fetch continue in order. A branch performs no register write.
- R7: A register written in stage 5 is already visible to a read in that same cycle. The instruction fetched three places after a producer sees the new value. The two instructions directly after it see the old value.
- R8: Register 0 always reads as zero, and a write to it is dropped without appearing on the write-back port.
- R9: With no bubbles in the program, one instruction completes in every cycle, so register writes appear in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_ld_we | input | 1 | Instruction memory loader write enable |
| imem_ld_addr | input | IMEM_AW | Instruction memory loader word index |
| imem_ld_data | input | 32 | Instruction memory loader data |
| dmem_ld_we | input | 1 | Data memory loader write enable |
| dmem_ld_addr | input | DMEM_AW | Data memory loader word index |
| dmem_ld_data | input | 32 | Data memory loader data |
| fetch_pc | output | 32 | Address being fetched this cycle |
| wb_we | output | 1 | A register is written this cycle |
| wb_reg | output | 5 | Register being written |
| wb_data | output | 32 | Value being written |
| st_we | output | 1 | A store writes data memory this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Stored word |

## Verification
The bench counts cycles from the first cycle after reset is released, which is the cycle that fetches address 0. For each instruction it notes its fetch cycle, and it expects the instruction's register write at fetch cycle + 4 and its store at fetch cycle + 3. After a taken branch in the memory stage, the new fetch address is expected in the following cycle. All outputs are sampled on the falling edge, and expected values are computed arithmetically in tables indexed by cycle. In every cycle the bench also checks that nothing is written where nothing is expected. This is how dropped writes, skipped delay slots and values read too early are caught: each shows up as a mismatch at a known cycle.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;
    localparam int NREG = 1 << RAW;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RAW-1:0]  ridx_t;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    regwr;
        logic    mem2reg;
        logic    memwr;
        logic    branch;
        logic    use_imm;
        alu_op_e op;
    } ctrl_t;

    typedef struct packed {
        word_t pc4;
        word_t instr;
    } ifid_t;

    typedef struct packed {
        ctrl_t ctrl;
        word_t pc4;
        word_t a;
        word_t b;
        word_t imm;
        ridx_t dst;
    } idex_t;

    typedef struct packed {
        ctrl_t ctrl;
        word_t res;
        logic  zero;
        word_t b;
        word_t target;
        ridx_t dst;
    } exmem_t;

    typedef struct packed {
        logic  regwr;
        word_t data;
        ridx_t dst;
    } memwb_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OP_REG: begin
                ctrl.regwr = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.op = ALU_ADD;
                    FN_SUB:  ctrl.op = ALU_SUB;
                    FN_AND:  ctrl.op = ALU_AND;
                    FN_OR:   ctrl.op = ALU_OR;
                    FN_SLT:  ctrl.op = ALU_SLT;
                    default: ctrl.regwr = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctrl.regwr   = 1'b1;
                ctrl.mem2reg = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.op      = ALU_ADD;
            end
            OP_STORE: begin
                ctrl.memwr   = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.op      = ALU_ADD;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.op     = ALU_SUB;
            end
            default: ctrl = '0;
        endcase
    end

    // R2: at most one memory/branch action, and none of them with a register write except load
    always_comb begin
        assert_ctrl_exclusive_R2: assert ($onehot0({ctrl.mem2reg, ctrl.memwr, ctrl.branch})
                                          && !((ctrl.memwr || ctrl.branch) && ctrl.regwr))
            else $error("decode produced conflicting controls");
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_op_e op,
    output word_t   y,
    output logic    zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (a == b);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t wa,
    input  word_t wd,
    input  ridx_t ra_a,
    input  ridx_t ra_b,
    output word_t rd_a,
    output word_t rd_b
);

    word_t regs [NREG];
    logic  wr_live;

    assign wr_live = we && (wa != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_live) begin
            regs[wa] <= wd;
        end
    end

    // write in the first half, read in the second: a same-cycle write is seen
    always_comb begin
        rd_a = (ra_a == '0) ? '0 : ((wr_live && wa == ra_a) ? wd : regs[ra_a]);
        rd_b = (ra_b == '0) ? '0 : ((wr_live && wa == ra_b) ? wd : regs[ra_b]);
    end

    // R7: a write lands in storage by the next cycle
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> regs[$past(wa)] == $past(wd))
        else $error("register write lost");

    // R8: register 0 never changes
    assert_r0_zero_R8: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0)
        else $error("register 0 modified");

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               imem_ld_we,
    input  logic [IMEM_AW-1:0] imem_ld_addr,
    input  logic [31:0]        imem_ld_data,
    input  logic               dmem_ld_we,
    input  logic [DMEM_AW-1:0] dmem_ld_addr,
    input  logic [31:0]        dmem_ld_data,
    output logic [31:0]        fetch_pc,
    output logic               wb_we,
    output logic [4:0]         wb_reg,
    output logic [31:0]        wb_data,
    output logic               st_we,
    output logic [31:0]        st_addr,
    output logic [31:0]        st_data
);

    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;

    word_t imem [IMEM_WORDS];
    word_t dmem [DMEM_WORDS];

    word_t  pc_q;
    ifid_t  ifid_q;
    idex_t  idex_q;
    exmem_t exmem_q;
    memwb_t memwb_q;

    // ---------------- fetch ----------------
    word_t instr_f, pc4_f, pc_next;
    logic  br_take;

    assign instr_f = imem[pc_q[IMEM_AW+1:2]];
    assign pc4_f   = pc_q + 32'd4;
    assign br_take = exmem_q.ctrl.branch && exmem_q.zero;
    assign pc_next = br_take ? exmem_q.target : pc4_f;

    always_ff @(posedge clk) begin
        if (imem_ld_we) imem[imem_ld_addr] <= imem_ld_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ifid_q <= '0;
        end else begin
            pc_q   <= pc_next;
            ifid_q <= '{pc4: pc4_f, instr: instr_f};
        end
    end

    // ---------------- decode / register read ----------------
    ctrl_t ctrl_d;
    ridx_t rs_d, rt_d, rd_d;
    word_t a_d, b_d;

    assign rs_d = ifid_q.instr[25:21];
    assign rt_d = ifid_q.instr[20:16];
    assign rd_d = ifid_q.instr[15:11];

    pipe5_decode u_decode (
        .opcode (ifid_q.instr[31:26]),
        .funct  (ifid_q.instr[5:0]),
        .ctrl   (ctrl_d)
    );

    pipe5_regfile u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (memwb_q.regwr),
        .wa   (memwb_q.dst),
        .wd   (memwb_q.data),
        .ra_a (rs_d),
        .ra_b (rt_d),
        .rd_a (a_d),
        .rd_b (b_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idex_q <= '0;
        end else begin
            idex_q.ctrl <= ctrl_d;
            idex_q.pc4  <= ifid_q.pc4;
            idex_q.a    <= a_d;
            idex_q.b    <= b_d;
            idex_q.imm  <= sext16(ifid_q.instr[15:0]);
            idex_q.dst  <= (ifid_q.instr[31:26] == OP_REG) ? rd_d : rt_d;
        end
    end

    // ---------------- execute ----------------
    word_t alu_b, alu_y, target_e;
    logic  zero_e;

    assign alu_b    = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.b;
    assign target_e = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};

    pipe5_alu u_alu (
        .a    (idex_q.a),
        .b    (alu_b),
        .op   (idex_q.ctrl.op),
        .y    (alu_y),
        .zero (zero_e)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exmem_q <= '0;
        end else begin
            exmem_q <= '{ctrl: idex_q.ctrl, res: alu_y, zero: zero_e,
                         b: idex_q.b, target: target_e, dst: idex_q.dst};
        end
    end

    // ---------------- memory ----------------
    word_t load_m;
    assign load_m = dmem[exmem_q.res[DMEM_AW+1:2]];

    always_ff @(posedge clk) begin
        if (dmem_ld_we) begin
            dmem[dmem_ld_addr] <= dmem_ld_data;
        end else if (!rst && exmem_q.ctrl.memwr) begin
            dmem[exmem_q.res[DMEM_AW+1:2]] <= exmem_q.b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            memwb_q <= '0;
        end else begin
            memwb_q.regwr <= exmem_q.ctrl.regwr;
            memwb_q.data  <= exmem_q.ctrl.mem2reg ? load_m : exmem_q.res;
            memwb_q.dst   <= exmem_q.dst;
        end
    end

    // ---------------- outputs ----------------
    assign fetch_pc = pc_q;
    assign wb_we    = memwb_q.regwr && (memwb_q.dst != '0);
    assign wb_reg   = memwb_q.dst;
    assign wb_data  = memwb_q.data;
    assign st_we    = exmem_q.ctrl.memwr;
    assign st_addr  = exmem_q.res;
    assign st_data  = exmem_q.b;

    logic unused_bits;
    assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IMEM_AW+2],
                           exmem_q.res[1:0], exmem_q.res[XLEN-1:DMEM_AW+2],
                           idex_q.imm[XLEN-1:XLEN-2]};

    // R1: sequential fetch when no branch is taken
    assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
        !br_take |=> fetch_pc == $past(fetch_pc) + 32'd4)
        else $error("fetch address did not advance by 4");

    // R6: a taken branch redirects fetch to the computed target
    assert_branch_pc_R6: assert property (@(posedge clk) disable iff (rst)
        br_take |=> fetch_pc == $past(exmem_q.target))
        else $error("taken branch not applied");

    // R5: a store never turns into a register write
    assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
        exmem_q.ctrl.memwr |=> !wb_we)
        else $error("store produced a register write");

endmodule

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;

    localparam int IAW = 8;
    localparam int DAW = 6;
    localparam int NI  = 1 << IAW;
    localparam int ND  = 1 << DAW;
    localparam int NC  = 300;
    localparam int NPAIR = 24;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           imem_ld_we = 1'b0;
    logic [IAW-1:0] imem_ld_addr = '0;
    logic [31:0]    imem_ld_data = '0;
    logic           dmem_ld_we = 1'b0;
    logic [DAW-1:0] dmem_ld_addr = '0;
    logic [31:0]    dmem_ld_data = '0;
    logic [31:0]    fetch_pc;
    logic           wb_we;
    logic [4:0]     wb_reg;
    logic [31:0]    wb_data;
    logic           st_we;
    logic [31:0]    st_addr;
    logic [31:0]    st_data;

    always #2 clk = ~clk;

    pipe5_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) i_pipe5_core (
        .clk(clk), .rst(rst),
        .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
        .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
        .fetch_pc(fetch_pc), .wb_we(wb_we), .wb_reg(wb_reg), .wb_data(wb_data),
        .st_we(st_we), .st_addr(st_addr), .st_data(st_data)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] prog [NI];
    logic [31:0] dat  [ND];
    logic        ew_v [NC];
    logic [4:0]  ew_r [NC];
    logic [31:0] ew_d [NC];
    string       ew_t [NC];
    logic        es_v [NC];
    logic [31:0] es_a [NC];
    logic [31:0] es_d [NC];
    string       es_t [NC];
    logic        ep_v [NC];
    logic [31:0] ep_pc[NC];
    string       ep_t [NC];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rins(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] iins(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] alu_ref(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'h20:   return a + b;
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic clear_all(input string idle_tag);
        for (int i = 0; i < NI; i++) prog[i] = '0;
        for (int i = 0; i < ND; i++) dat[i] = '0;
        for (int i = 0; i < NC; i++) begin
            ew_v[i] = 1'b0; ew_r[i] = '0; ew_d[i] = '0; ew_t[i] = idle_tag;
            es_v[i] = 1'b0; es_a[i] = '0; es_d[i] = '0; es_t[i] = idle_tag;
            ep_v[i] = 1'b0; ep_pc[i] = '0; ep_t[i] = idle_tag;
        end
    endtask

    task automatic put_wb(input int c, input int r, input logic [31:0] d, input string t);
        ew_v[c] = 1'b1; ew_r[c] = 5'(r); ew_d[c] = d; ew_t[c] = t;
    endtask

    task automatic put_st(input int c, input logic [31:0] a, input logic [31:0] d, input string t);
        es_v[c] = 1'b1; es_a[c] = a; es_d[c] = d; es_t[c] = t;
    endtask

    task automatic put_pc(input int c, input logic [31:0] p, input string t);
        ep_v[c] = 1'b1; ep_pc[c] = p; ep_t[c] = t;
    endtask

    // load both memories under reset, check the reset state, release at a falling edge
    task automatic load_and_release();
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            imem_ld_we = 1'b1; imem_ld_addr = IAW'(i); imem_ld_data = prog[i];
            @(negedge clk);
        end
        imem_ld_we = 1'b0;
        for (int i = 0; i < ND; i++) begin
            dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(i); dmem_ld_data = dat[i];
            @(negedge clk);
        end
        dmem_ld_we = 1'b0;
        @(negedge clk);
        check(fetch_pc == 32'd0, "R1", "reset fetch address", fetch_pc, 32'd0);
        check(!wb_we, "R1", "reset write-back idle", {31'd0, wb_we}, 32'd0);
        check(!st_we, "R1", "reset store idle", {31'd0, st_we}, 32'd0);
        rst = 1'b0;
    endtask

    // cycle k = number of rising edges since reset release; sampled at falling edges
    task automatic run(input int ncyc);
        for (int k = 0; k < ncyc; k++) begin
            if (ew_v[k])
                check(wb_we && wb_reg == ew_r[k] && wb_data == ew_d[k], ew_t[k],
                      $sformatf("write-back cycle %0d reg %0d (exp reg %0d, we %0d)", k, wb_reg, ew_r[k], wb_we),
                      wb_data, ew_d[k]);
            else
                check(!wb_we, ew_t[k], $sformatf("unexpected write-back cycle %0d", k),
                      {31'd0, wb_we}, 32'd0);
            if (es_v[k])
                check(st_we && st_addr == es_a[k] && st_data == es_d[k], es_t[k],
                      $sformatf("store cycle %0d addr %h (exp addr %h, we %0d)", k, st_addr, es_a[k], st_we),
                      st_data, es_d[k]);
            else
                check(!st_we, es_t[k], $sformatf("unexpected store cycle %0d", k),
                      {31'd0, st_we}, 32'd0);
            if (ep_v[k])
                check(fetch_pc == ep_pc[k], ep_t[k], $sformatf("fetch address cycle %0d", k),
                      fetch_pc, ep_pc[k]);
            @(negedge clk);
        end
    endtask

    // sweep of register operations over loaded operand pairs (R3, R4, R7, R9)
    task automatic prog_sweep();
        logic [5:0] fns [5];
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
        clear_all("R9");
        for (int k = 0; k < NPAIR; k++) begin
            logic [31:0] a, b;
            int base;
            a = 32'(k) * 32'h9E3779B9;
            b = (k % 4 == 1) ? a : (32'(k) * 32'h7F4A7C15 + ((k % 2 == 1) ? 32'h80000000 : 32'd0));
            dat[2*k]     = a;
            dat[2*k + 1] = b;
            base = 9 * k;
            prog[base]     = iins(6'h23, 0, 1, 16'(8*k));
            prog[base + 1] = iins(6'h23, 0, 2, 16'(8*k + 4));
            put_wb(base + 4, 1, a, "R4");
            put_wb(base + 5, 2, b, "R4");
            for (int f = 0; f < 5; f++) begin
                prog[base + 4 + f] = rins(1, 2, 3 + f, fns[f]);
                put_wb(base + 8 + f, 3 + f, alu_ref(fns[f], a, b), (f == 0) ? "R7" : "R3");
            end
        end
        for (int c = 0; c < 20; c++) put_pc(c, 32'(4*c), "R1");
    endtask

    // hazards, r0, store/load, delay slots, unsupported codes
    task automatic prog_directed();
        clear_all("R9");
        dat[0] = 32'h11; dat[1] = 32'h22; dat[3] = 32'h33;
        prog[0]  = iins(6'h23, 0, 1, 16'd0);          put_wb(4, 1, 32'h11, "R4");
        prog[1]  = rins(1, 0, 2, 6'h20);              put_wb(5, 2, 32'h0,  "R7");
        prog[2]  = rins(1, 0, 3, 6'h20);              put_wb(6, 3, 32'h0,  "R7");
        prog[3]  = rins(1, 0, 4, 6'h20);              put_wb(7, 4, 32'h11, "R7");
        prog[4]  = rins(1, 1, 0, 6'h20);              ew_t[8] = "R8";
        prog[5]  = rins(0, 1, 5, 6'h20);              put_wb(9, 5, 32'h11, "R8");
        prog[6]  = iins(6'h2B, 0, 4, 16'd8);          put_st(9, 32'd8, 32'h11, "R5"); ew_t[10] = "R5";
        prog[7]  = iins(6'h23, 0, 6, 16'd8);          put_wb(11, 6, 32'h11, "R5");
        prog[8]  = iins(6'h2B, 4, 1, 16'hFFF7);       put_st(11, 32'd8, 32'h11, "R5"); ew_t[12] = "R5";
        prog[9]  = iins(6'h04, 1, 4, 16'd6);          ew_t[13] = "R6";
        prog[10] = rins(1, 1, 8, 6'h20);              put_wb(14, 8, 32'h22, "R6");
        prog[11] = rins(1, 4, 9, 6'h20);              put_wb(15, 9, 32'h22, "R6");
        prog[12] = rins(1, 0, 10, 6'h22);             put_wb(16, 10, 32'h11, "R6");
        prog[13] = rins(1, 1, 20, 6'h20);
        prog[14] = rins(1, 1, 21, 6'h20);
        prog[15] = rins(1, 1, 22, 6'h20);
        prog[16] = iins(6'h04, 1, 2, 16'd5);          ew_t[17] = "R6";
        prog[17] = rins(1, 4, 11, 6'h25);             put_wb(18, 11, 32'h11, "R3");
        prog[18] = rins(1, 2, 12, 6'h24);             put_wb(19, 12, 32'h0,  "R3");
        prog[19] = rins(2, 1, 13, 6'h2A);             put_wb(20, 13, 32'h1,  "R3");
        prog[20] = rins(1, 1, 14, 6'h00);             ew_t[21] = "R2";
        prog[21] = iins(6'h3F, 1, 15, 16'h0020);      ew_t[22] = "R2"; es_t[21] = "R2";
        prog[22] = iins(6'h23, 4, 16, 16'hFFFC);      put_wb(23, 16, 32'h33, "R4");
        put_pc(1, 32'd4, "R1");
        put_pc(12, 32'd48, "R6");
        put_pc(13, 32'd64, "R6");
        put_pc(16, 32'd76, "R6");
        put_pc(17, 32'd80, "R6");
    endtask

    initial begin
        #(4.0 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        prog_sweep();
        load_and_release();
        run(9 * NPAIR + 10);
        prog_directed();
        load_and_release();
        run(40);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule